// File: doc/BRIEF.md
# Sound Processor Command Latch and Address Glue

This block sits next to the sound processor. It gives the main processor a one-byte mailbox. A main-side write stores the byte and raises an interrupt request to the sound processor. The request stays high until the sound processor reads the mailbox.

The block also decodes the sound processor's 16-bit address space. It produces chip selects for the work RAM, the program ROM and the FM synthesiser. It answers reads of the mailbox and of the speech-busy flag. A speech control register drives the reset and start pins of a sample-playback chip. A bank register is loaded from the FM chip's second I/O port and supplies the base address of a 128 KB window in the sample ROM.

The FM synthesiser, the speech decoder, the RAM and the ROMs are outside the block. When the glue is not returning its own read data, the external devices drive the sound processor's data bus.

Top module: `snd_glue_top`

## Requirements
- R1: After synchronous reset, `snd_irq`, `spch_rst`, `spch_go` and `bank_base` are all 0, and a mailbox read returns 0x00.
- R2: When `main_cmd_we` is high at a clock edge, the mailbox takes `main_cmd_data` and `snd_irq` is 1 from that edge onward.
- R3: A sound read (`snd_rd`) of 0x6000 returns the mailbox byte in the same cycle. If `main_cmd_we` is low at that edge, `snd_irq` is 0 after the edge.
- R4: A main write while `snd_irq` is high overwrites the mailbox and leaves `snd_irq` high. A main write at the same edge as a mailbox read also leaves `snd_irq` high.
- R5: A sound write (`snd_wr`) to 0x3000 loads `spch_rst` from data bit 0 and `spch_go` from data bit 1. Both hold until the next such write.
- R6: A sound read of 0x4000 returns `spch_busy` in bit 0, with bits 7:1 all 1.
- R7: When `fm_portb_we` is high at a clock edge, `bank_base` becomes bits 5:3 of `fm_portb_data` times 0x20000 (20-bit result).
- R8: While `snd_rd` or `snd_wr` is high, the selects assert as follows. `sel_ram` asserts for 0x0000–0x07FF. `sel_fm` asserts for 0x1000 and 0x1001, with `fm_a0` equal to address bit 0. `sel_rom` asserts for 0x8000–0xFFFF. No select asserts for any other address or when there is no access. At most one select is high at a time.
- R9: A write to 0x5000, 0x6000 or 0x4000 and a read of 0x3000 change no register: `snd_irq`, `spch_rst`, `spch_go` and `bank_base` keep their values.
- R10: `rd_own` is high exactly during reads of 0x4000 or 0x6000. Otherwise `snd_rdata` is 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| main_cmd_we | input | 1 | Main processor write strobe to the mailbox |
| main_cmd_data | input | 8 | Mailbox byte from the main processor |
| snd_addr | input | 16 | Sound processor address |
| snd_rd | input | 1 | Sound processor read strobe |
| snd_wr | input | 1 | Sound processor write strobe |
| snd_wdata | input | 8 | Sound processor write data |
| fm_portb_we | input | 1 | FM chip port B output update strobe |
| fm_portb_data | input | 8 | FM chip port B output value |
| spch_busy | input | 1 | Busy flag from the speech decoder |
| snd_irq | output | 1 | Held interrupt request to the sound processor |
| snd_rdata | output | 8 | Read data produced by the glue |
| rd_own | output | 1 | Glue drives the read data this cycle |
| sel_ram | output | 1 | Work RAM select |
| sel_fm | output | 1 | FM chip select |
| fm_a0 | output | 1 | FM register/data address bit |
| sel_rom | output | 1 | Program ROM select |
| spch_rst | output | 1 | Speech decoder reset level |
| spch_go | output | 1 | Speech decoder start level |
| bank_base | output | 20 | Sample ROM bank base address |

## Verification
A stale or lost mailbox byte shows on `snd_rdata` at the next read of 0x6000. A stuck or wrongly cleared request shows on `snd_irq` one edge after the write or the read that should have changed it. A wrong decode shows at once on the selects or on `rd_own`. A speech or bank register that loads at the wrong time shows on `spch_rst`, `spch_go` or `bank_base` one edge after the stray access. Because of this, the outputs are compared with a reference model in every cycle.

// File: rtl/sndg_pkg.sv
package sndg_pkg;
    localparam int ADDR_W    = 16;
    localparam int DATA_W    = 8;
    localparam int BANK_BITS = 3;
    localparam int BANK_LSB  = 3;
    localparam int BANK_SHIFT = 17;
    localparam int BASE_W    = BANK_SHIFT + BANK_BITS;

    localparam logic [ADDR_W-1:0] RAM_TOP   = 16'h07FF;
    localparam logic [ADDR_W-1:0] FM_ADDR   = 16'h1000;
    localparam logic [ADDR_W-1:0] SPCTL_ADR = 16'h3000;
    localparam logic [ADDR_W-1:0] BUSY_ADR  = 16'h4000;
    localparam logic [ADDR_W-1:0] QUIET_ADR = 16'h5000;
    localparam logic [ADDR_W-1:0] CMD_ADR   = 16'h6000;

    typedef enum logic [2:0] {
        RG_NONE, RG_RAM, RG_FM, RG_SPCTL, RG_BUSY, RG_QUIET, RG_CMD, RG_ROM
    } region_e;

    typedef struct packed {
        logic ram;
        logic fm;
        logic rom;
    } csel_t;

    function automatic region_e map_addr(input logic [ADDR_W-1:0] a);
        region_e r;
        if (a[ADDR_W-1])                 r = RG_ROM;
        else if (a <= RAM_TOP)           r = RG_RAM;
        else if (a[ADDR_W-1:1] == FM_ADDR[ADDR_W-1:1]) r = RG_FM;
        else if (a == SPCTL_ADR)         r = RG_SPCTL;
        else if (a == BUSY_ADR)          r = RG_BUSY;
        else if (a == QUIET_ADR)         r = RG_QUIET;
        else if (a == CMD_ADR)           r = RG_CMD;
        else                             r = RG_NONE;
        return r;
    endfunction
endpackage

// File: rtl/sndg_decode.sv
module sndg_decode
    import sndg_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    input  logic              rd,
    input  logic              wr,
    output csel_t             sel,
    output logic              spctl_wr,
    output logic              cmd_rd,
    output logic              busy_rd
);
    region_e rg;
    logic    acc;

    always_comb begin
        rg       = map_addr(addr);
        acc      = rd | wr;
        sel.ram  = acc && (rg == RG_RAM);
        sel.fm   = acc && (rg == RG_FM);
        sel.rom  = acc && (rg == RG_ROM);
        spctl_wr = wr && (rg == RG_SPCTL);
        cmd_rd   = rd && (rg == RG_CMD);
        busy_rd  = rd && (rg == RG_BUSY);
    end

    // R8: region selects are mutually exclusive
    always_comb begin
        a_r8_sel_onehot: assert ($onehot0({sel.ram, sel.fm, sel.rom, cmd_rd, busy_rd}));
    end
endmodule

// File: rtl/sndg_cmd_latch.sv
module sndg_cmd_latch
    import sndg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              host_we,
    input  logic [DATA_W-1:0] host_data,
    input  logic              ack,
    output logic [DATA_W-1:0] held,
    output logic              irq
);
    always_ff @(posedge clk) begin
        if (rst) begin
            held <= '0;
            irq  <= 1'b0;
        end else if (host_we) begin
            held <= host_data;
            irq  <= 1'b1;
        end else if (ack) begin
            irq  <= 1'b0;
        end
    end

    a_r2_irq_raise: assert property (@(posedge clk) disable iff (rst)
        host_we |=> irq);
    a_r2_latch_load: assert property (@(posedge clk) disable iff (rst)
        host_we |=> held == $past(host_data));
    a_r3_irq_clear: assert property (@(posedge clk) disable iff (rst)
        (ack && !host_we) |=> !irq);
    a_r9_irq_hold: assert property (@(posedge clk) disable iff (rst)
        (!ack && !host_we) |=> $stable(irq) && $stable(held));
endmodule

// File: rtl/sndg_spch_ctrl.sv
module sndg_spch_ctrl
    import sndg_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 ctl_we,
    input  logic [DATA_W-1:0]    ctl_data,
    input  logic                 bank_we,
    input  logic [DATA_W-1:0]    bank_data,
    output logic                 spch_rst,
    output logic                 spch_go,
    output logic [BANK_BITS-1:0] bank
);
    always_ff @(posedge clk) begin
        if (rst) begin
            spch_rst <= 1'b0;
            spch_go  <= 1'b0;
        end else if (ctl_we) begin
            spch_rst <= ctl_data[0];
            spch_go  <= ctl_data[1];
        end
    end

    always_ff @(posedge clk) begin
        if (rst)          bank <= '0;
        else if (bank_we) bank <= bank_data[BANK_LSB +: BANK_BITS];
    end

    a_r5_ctl_load: assert property (@(posedge clk) disable iff (rst)
        ctl_we |=> (spch_rst == $past(ctl_data[0])) && (spch_go == $past(ctl_data[1])));
    a_r9_ctl_hold: assert property (@(posedge clk) disable iff (rst)
        !ctl_we |=> $stable(spch_rst) && $stable(spch_go));
    a_r7_bank_hold: assert property (@(posedge clk) disable iff (rst)
        !bank_we |=> $stable(bank));
endmodule

// File: rtl/snd_glue_top.sv
module snd_glue_top
    import sndg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              main_cmd_we,
    input  logic [DATA_W-1:0] main_cmd_data,
    input  logic [ADDR_W-1:0] snd_addr,
    input  logic              snd_rd,
    input  logic              snd_wr,
    input  logic [DATA_W-1:0] snd_wdata,
    input  logic              fm_portb_we,
    input  logic [DATA_W-1:0] fm_portb_data,
    input  logic              spch_busy,
    output logic              snd_irq,
    output logic [DATA_W-1:0] snd_rdata,
    output logic              rd_own,
    output logic              sel_ram,
    output logic              sel_fm,
    output logic              fm_a0,
    output logic              sel_rom,
    output logic              spch_rst,
    output logic              spch_go,
    output logic [BASE_W-1:0] bank_base
);
    csel_t                sel;
    logic                 spctl_wr, cmd_rd, busy_rd;
    logic [DATA_W-1:0]    mbox;
    logic [BANK_BITS-1:0] bank;

    sndg_decode u_dec (
        .addr(snd_addr), .rd(snd_rd), .wr(snd_wr),
        .sel(sel), .spctl_wr(spctl_wr), .cmd_rd(cmd_rd), .busy_rd(busy_rd)
    );

    sndg_cmd_latch u_mbox (
        .clk(clk), .rst(rst),
        .host_we(main_cmd_we), .host_data(main_cmd_data),
        .ack(cmd_rd), .held(mbox), .irq(snd_irq)
    );

    sndg_spch_ctrl u_spch (
        .clk(clk), .rst(rst),
        .ctl_we(spctl_wr), .ctl_data(snd_wdata),
        .bank_we(fm_portb_we), .bank_data(fm_portb_data),
        .spch_rst(spch_rst), .spch_go(spch_go), .bank(bank)
    );

    always_comb begin
        sel_ram   = sel.ram;
        sel_fm    = sel.fm;
        sel_rom   = sel.rom;
        fm_a0     = snd_addr[0];
        rd_own    = cmd_rd | busy_rd;
        bank_base = {bank, {BANK_SHIFT{1'b0}}};
        if (cmd_rd)       snd_rdata = mbox;
        else if (busy_rd) snd_rdata = {{(DATA_W-1){1'b1}}, spch_busy};
        else              snd_rdata = '1;
    end

    // R10: idle bus reads back all ones
    always_comb begin
        a_r10_idle_ones: assert (rd_own || snd_rdata == '1);
    end
    // R4: a write racing a read keeps the request
    a_r4_race_keeps_irq: assert property (@(posedge clk) disable iff (rst)
        (main_cmd_we && cmd_rd) |=> snd_irq);
endmodule

// File: tb/test_snd_glue_top.sv
module test_snd_glue_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        main_cmd_we = 1'b0;
    logic [7:0]  main_cmd_data = '0;
    logic [15:0] snd_addr = '0;
    logic        snd_rd = 1'b0, snd_wr = 1'b0;
    logic [7:0]  snd_wdata = '0;
    logic        fm_portb_we = 1'b0;
    logic [7:0]  fm_portb_data = '0;
    logic        spch_busy = 1'b0;
    logic        snd_irq, rd_own, sel_ram, sel_fm, fm_a0, sel_rom, spch_rst, spch_go;
    logic [7:0]  snd_rdata;
    logic [19:0] bank_base;

    int checks = 0, failures = 0;
    int m_latch = 0, m_irq = 0, m_rst = 0, m_go = 0, m_bank = 0;

    always #2 clk = ~clk;

    snd_glue_top i_snd_glue_top (.*);

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic compare();
        int acc, own, rdx, a;
        a   = snd_addr;
        acc = snd_rd || snd_wr;
        own = snd_rd && (a == 'h6000 || a == 'h4000);
        if (snd_rd && a == 'h6000)      rdx = m_latch;
        else if (snd_rd && a == 'h4000) rdx = 'hFE | spch_busy;
        else                            rdx = 'hFF;
        chk("R1/R2/R3/R4/R9 irq", snd_irq, m_irq);
        chk("R3/R6/R10 rdata", snd_rdata, rdx);
        chk("R10 rd_own", rd_own, own);
        chk("R8 sel_ram", sel_ram, acc && a <= 'h07FF);
        chk("R8 sel_fm", sel_fm, acc && (a == 'h1000 || a == 'h1001));
        chk("R8 sel_rom", sel_rom, acc && a >= 'h8000);
        chk("R8 fm_a0", fm_a0, a & 1);
        chk("R1/R5/R9 spch_rst", spch_rst, m_rst);
        chk("R1/R5/R9 spch_go", spch_go, m_go);
        chk("R1/R7/R9 bank_base", bank_base, m_bank * 'h20000);
    endtask

    // one cycle: drive at negedge, compare, update model at posedge
    task automatic cyc(input bit mwe, input int md, input int ad, input bit rd,
                       input bit wr, input int wd, input bit fwe, input int fd,
                       input bit busy);
        main_cmd_we = mwe; main_cmd_data = md[7:0];
        snd_addr = ad[15:0]; snd_rd = rd; snd_wr = wr; snd_wdata = wd[7:0];
        fm_portb_we = fwe; fm_portb_data = fd[7:0]; spch_busy = busy;
        #1 compare();
        @(posedge clk);
        if (mwe) begin m_latch = md & 'hFF; m_irq = 1; end
        else if (rd && ad == 'h6000) m_irq = 0;
        if (wr && ad == 'h3000) begin m_rst = wd & 1; m_go = (wd >> 1) & 1; end
        if (fwe) m_bank = (fd >> 3) & 7;
        @(negedge clk);
    endtask

    initial begin
        #400000;
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1: reset state, mailbox reads 0
        cyc(0, 0, 'h6000, 1, 0, 0, 0, 0, 0);
        cyc(0, 0, 'h0000, 0, 0, 0, 0, 0, 0);
        // R2: main write raises request
        cyc(1, 'hA5, 'h0000, 0, 0, 0, 0, 0, 0);
        cyc(0, 0, 'h0100, 1, 0, 0, 0, 0, 0);
        // R4: overwrite while pending
        cyc(1, 'h3C, 'h0000, 0, 0, 0, 0, 0, 0);
        // R9: stray accesses leave state alone
        cyc(0, 0, 'h5000, 0, 1, 'hFF, 0, 0, 0);
        cyc(0, 0, 'h6000, 0, 1, 'h00, 0, 0, 0);
        cyc(0, 0, 'h4000, 0, 1, 'h03, 0, 0, 0);
        cyc(0, 0, 'h3000, 1, 0, 'h03, 0, 0, 0);
        // R3: read returns byte and clears request
        cyc(0, 0, 'h6000, 1, 0, 0, 0, 0, 0);
        cyc(0, 0, 'h0000, 0, 0, 0, 0, 0, 0);
        // R4: write at same edge as read keeps request
        cyc(1, 'h11, 'h0000, 0, 0, 0, 0, 0, 0);
        cyc(1, 'h22, 'h6000, 1, 0, 0, 0, 0, 0);
        cyc(0, 0, 'h6000, 1, 0, 0, 0, 0, 0);
        cyc(0, 0, 'h0000, 0, 0, 0, 0, 0, 0);
        // R5: speech control bits
        cyc(0, 0, 'h3000, 0, 1, 'h01, 0, 0, 0);
        cyc(0, 0, 'h3000, 0, 1, 'hFE, 0, 0, 0);
        cyc(0, 0, 'h3000, 0, 1, 'h03, 0, 0, 0);
        cyc(0, 0, 'h3000, 0, 1, 'h00, 0, 0, 0);
        // R6: busy read both levels
        cyc(0, 0, 'h4000, 1, 0, 0, 0, 0, 1);
        cyc(0, 0, 'h4000, 1, 0, 0, 0, 0, 0);
        // R7: bank from port B bits 5:3
        cyc(0, 0, 'h0000, 0, 0, 0, 1, 'h38, 0);
        cyc(0, 0, 'h0000, 0, 0, 0, 1, 'hC7, 0);
        cyc(0, 0, 'h0000, 0, 0, 0, 1, 'h28, 0);
        cyc(0, 0, 'h0000, 0, 0, 0, 0, 'hFF, 0);
        // R8: decode edges
        for (int k = 0; k < 12; k++) begin
            int ad;
            case (k)
                0: ad = 'h0000; 1: ad = 'h07FF; 2: ad = 'h0800; 3: ad = 'h1000;
                4: ad = 'h1001; 5: ad = 'h1002; 6: ad = 'h0FFF; 7: ad = 'h7FFF;
                8: ad = 'h8000; 9: ad = 'hFFFF; 10: ad = 'h2000; default: ad = 'h5000;
            endcase
            cyc(0, 0, ad, 1, 0, 0, 0, 0, 0);
            cyc(0, 0, ad, 0, 1, 'h55, 0, 0, 0);
            cyc(0, 0, ad, 0, 0, 0, 0, 0, 0);
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule